// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge lets a host reach a word-indexed internal 32-bit register file through a small window of four 64-bit host registers. A write to the internal file takes two steps. The host first loads a staging register with the data. It then writes a command word that carries the word index and a write bit. A read works the same way: the host writes a command word with the read bit set. The bridge runs one access on the internal bus and captures the returned word into a result register, which the host then reads.

A fixed, read-only identity word gives the device identifier, the transmit FIFO depth, the highest supported bus-rate code and the reference clock frequency in MHz.

Host window (selected by `host_sel`): 0 = identity word, 1 = staging data, 2 = command word (reads as zero), 3 = read result.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, `host_rdata` is zero, `int_wr` and `int_rd` are low, and the read-result register (window 3) reads as zero.
- R2: Window 0 reads the identity word: bits 19:0 = 0xEE011, bits 31:24 = FIFO depth (default 32), bits 35:32 = rate code (0 = 100 kHz, 1 = 400 kHz, default 1), bits 47:40 = reference clock in MHz (default 100). All other bits are zero.
- R3: Window 1 reads back all 64 bits last written to it. Only bits 31:0 of that value appear on `int_wdata`.
- R4: A command word (window 2) with bit 63 set makes `int_wr` high for exactly the one cycle after the host write. During that cycle `int_idx` equals command bits 15:0 and `int_wdata` carries the staged data.
- R5: A command word with bit 62 set and bit 63 clear makes `int_rd` high for exactly the one cycle after the host write, with `int_idx` equal to command bits 15:0.
- R6: A command word with both bit 63 and bit 62 set is treated as a write only: `int_wr` pulses and `int_rd` stays low.
- R7: A command word with neither bit 63 nor bit 62 set starts no access and leaves the read-result register unchanged.
- R8: The word on `int_rdata` during the `int_rd` cycle is captured into the read-result register. Window 3 returns it in bits 31:0 with bits 63:32 zero, and holds it until the next read command.
- R9: `host_rdata` updates on the clock edge that samples `host_rd` and holds otherwise. A read of window 3 issued in the cycle right after a read command returns the previous result. The next read returns the new one.
- R10: `int_wr` and `int_rd` are never high together, and each pulse comes from a command-word write in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_sel | input | 2 | Host window select |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, registered |
| int_wr | output | 1 | Internal write pulse |
| int_rd | output | 1 | Internal read pulse |
| int_idx | output | 16 | Internal word index |
| int_wdata | output | 32 | Internal write data |
| int_rdata | input | 32 | Internal read data, valid during `int_rd` |

## Verification
A command write sampled at edge E puts the internal pulse on the bus from E to E+1. The captured read word sits in the result register from E+1 onward. A host read sampled at edge F shows on `host_rdata` after F. The bench drives and samples on falling edges. It checks the internal pulse in the half-cycle just after the command edge, and checks the result register with a back-to-back double read: the first read must show the old value and the second the new one. A sweep writes and reads back every word of a 16-entry stub, and directed cases cover the command encodings and the identity word.

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int RATE_CODE  = 1,
  parameter int REF_MHZ    = 100,
  parameter logic [19:0] DEV_ID = 20'hEE011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  output logic              int_wr,
  output logic              int_rd,
  output logic [IDX_W-1:0]  int_idx,
  output logic [DATA_W-1:0] int_wdata,
  input  logic [DATA_W-1:0] int_rdata
);
  localparam int WR_BIT = 63;
  localparam int RD_BIT = 62;
  localparam logic [1:0] SEL_ID = 2'd0, SEL_DATA = 2'd1, SEL_CMD = 2'd2, SEL_RES = 2'd3;

  localparam logic [63:0] ID_WORD = {16'd0, 8'(REF_MHZ), 4'd0, 4'(RATE_CODE),
                                     8'(FIFO_DEPTH), 4'd0, DEV_ID};

  logic [63:0]       stage_q;
  logic [DATA_W-1:0] result_q;
  logic              cmd_wr, go_wr, go_rd;

  assign cmd_wr    = host_wr && host_sel == SEL_CMD;
  assign go_wr     = cmd_wr && host_wdata[WR_BIT];
  assign go_rd     = cmd_wr && !host_wdata[WR_BIT] && host_wdata[RD_BIT];
  assign int_wdata = stage_q[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q  <= '0;
      result_q <= '0;
      int_wr   <= 1'b0;
      int_rd   <= 1'b0;
      int_idx  <= '0;
    end else begin
      if (host_wr && host_sel == SEL_DATA) stage_q <= host_wdata;
      int_wr <= go_wr;
      int_rd <= go_rd;
      if (go_wr || go_rd) int_idx <= host_wdata[IDX_W-1:0];
      if (int_rd) result_q <= int_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_rd) begin
      case (host_sel)
        SEL_ID:   host_rdata <= ID_WORD;
        SEL_DATA: host_rdata <= stage_q;
        SEL_CMD:  host_rdata <= '0;
        default:  host_rdata <= {{(64-DATA_W){1'b0}}, result_q};
      endcase
    end
  end
endmodule

// File: rtl/ind_reg_bridge_chk.sv
module ind_reg_bridge_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [1:0]        host_sel,
  input logic              c_wr,
  input logic              c_rd,
  input logic [IDX_W-1:0]  c_idx,
  input logic [63:DATA_W]  rdata_hi,
  input logic              int_wr,
  input logic              int_rd,
  input logic [IDX_W-1:0]  int_idx
);
  logic cmd;
  assign cmd = host_wr && host_sel == 2'd2;

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(int_wr && int_rd));
  a_r10_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    (int_wr || int_rd) |-> $past(cmd));
  a_r4_write_go: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && c_wr) |=> (int_wr && !int_rd && int_idx == $past(c_idx)));
  a_r5_read_go: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && !c_wr && c_rd) |=> (int_rd && !int_wr && int_idx == $past(c_idx)));
  a_r7_idle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && !c_wr && !c_rd) |=> (!int_wr && !int_rd));
  a_r8_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel == 2'd3) |=> (rdata_hi == '0));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd && $past(rst_n)) |=> $stable(rdata_hi));
endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
  .c_wr(host_wdata[63]), .c_rd(host_wdata[62]), .c_idx(host_wdata[IDX_W-1:0]),
  .rdata_hi(host_rdata[63:DATA_W]), .int_wr(int_wr), .int_rd(int_rd), .int_idx(int_idx)
);

// File: tb/tb_ind_reg_bridge.sv
module tb_ind_reg_bridge;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [1:0] host_sel = 0;
  logic [63:0] host_wdata = 0, host_rdata;
  logic int_wr, int_rd;
  logic [15:0] int_idx;
  logic [31:0] int_wdata, int_rdata;
  logic [31:0] mem [16];
  logic [31:0] model [16];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ind_reg_bridge dut (.*);

  assign int_rdata = mem[int_idx[3:0]];
  always @(posedge clk) if (int_wr) mem[int_idx[3:0]] <= int_wdata;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] sel, input logic [63:0] d);
    host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 0; host_wdata = 0;
  endtask

  task automatic hread(input logic [1:0] sel, output logic [63:0] q);
    host_rd = 1; host_sel = sel;
    @(negedge clk);
    host_rd = 0;
    q = host_rdata;
  endtask

  function automatic logic [63:0] cmdw(input bit w, input bit r, input logic [15:0] idx);
    return {w, r, 46'd0, idx};
  endfunction

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] q, prev;
    for (int i = 0; i < 16; i++) begin mem[i] = 0; model[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 rdata", host_rdata, 0);
    chk("R1 pulses", {int_wr, int_rd}, 0);
    hread(2'd3, q); chk("R1 result", q, 0);
    // R2
    hread(2'd0, q);
    chk("R2 id word", q, {16'd0, 8'd100, 4'd0, 4'd1, 8'd32, 4'd0, 20'hEE011});
    // R3
    hwrite(2'd1, 64'hDEADBEEF_12345678);
    hread(2'd1, q); chk("R3 readback", q, 64'hDEADBEEF_12345678);
    chk("R3 low only", {32'd0, int_wdata}, 64'h12345678);
    // sweep writes: R4
    for (int i = 0; i < 16; i++) begin
      logic [31:0] d;
      d = (i * 32'h01030507) ^ 32'hA5A5_0F0F;
      hwrite(2'd1, {~d, d});
      hwrite(2'd2, cmdw(1, 0, 16'(i)));
      chk("R4 wr pulse", {int_wr, int_rd}, 2'b10);
      chk("R4 idx", int_idx, 64'(i));
      chk("R4 wdata", int_wdata, d);
      model[i] = d;
      @(negedge clk);
      chk("R4 one cycle", {int_wr, int_rd}, 0);
    end
    // sweep reads: R5, R8, R9
    prev = 0;
    for (int i = 15; i >= 0; i--) begin
      hwrite(2'd2, cmdw(0, 1, 16'(i)));
      chk("R5 rd pulse", {int_wr, int_rd}, 2'b01);
      chk("R5 idx", int_idx, 64'(i));
      hread(2'd3, q); chk("R9 first read stale", q, prev);
      chk("R5 one cycle", {int_wr, int_rd}, 0);
      hread(2'd3, q); chk("R8 result", q, {32'd0, model[i]});
      prev = q;
    end
    // R9 hold without read
    repeat (3) @(negedge clk);
    chk("R9 hold", host_rdata, prev);
    // R7 ignored command
    hwrite(2'd2, cmdw(0, 0, 16'd3));
    chk("R7 no pulse", {int_wr, int_rd}, 0);
    chk("R7 idx kept", int_idx, 64'd0);
    @(negedge clk);
    chk("R7 no pulse later", {int_wr, int_rd}, 0);
    hread(2'd3, q); chk("R7 result kept", q, prev);
    // R6 both bits
    hwrite(2'd1, 64'hFFFF0000_CAFEF00D);
    hwrite(2'd2, cmdw(1, 1, 16'h0105));
    chk("R6 write only", {int_wr, int_rd}, 2'b10);
    chk("R6 idx", int_idx, 64'h0105);
    model[5] = 32'hCAFEF00D;
    @(negedge clk);
    hwrite(2'd2, cmdw(0, 1, 16'd5));
    @(negedge clk);
    hread(2'd3, q); chk("R6 stored", q, {32'd0, model[5]});
    chk("R10 idle", {int_wr, int_rd}, 0);
    hread(2'd2, q); chk("R3 cmd reads zero", q, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule